// File: doc/BRIEF.md
# I2C TPM Register Bridge

This block turns byte events from an I2C target PHY into accesses on a 32-bit TPM register bus. A write transfer starts with one index byte that picks a register. Data bytes for most registers go into a small local buffer and are sent as one back-end write when the stop arrives. Bytes sent to the data FIFO go straight through, one back-end write per byte. A read transfer that follows an index write fetches the register value once and then returns it one byte at a time. The FIFO is the exception: it is read again for every byte. The locality selector and the checksum enable are held inside the bridge. The locality also sets the upper address bits of every back-end access.

The PHY side is a valid/ready event stream. `evt_valid` may rise at any time and must hold with a stable kind and byte until `evt_ready` is high at a clock edge. `evt_ready` is high unless the offered event needs a back-end access, in which case it follows `be_req_ready`. Each accepted event produces exactly one `rsp_valid` pulse in the next cycle, carrying ACK or NAK and the read byte. The back-end request is raised combinationally by the offered event. Write data and read data are exchanged in the cycle where `be_req_valid` and `be_req_ready` are both high. No response buffering is needed, because the PHY offers at most one event at a time.

Top module: `i2c_tpm_bridge`

## Requirements
- R1: Event kind codes are: 0 start-of-write, 1 start-of-read, 2 byte written, 3 read request, 4 stop. The first written byte after a start-of-write is an index, decoded through this map:
  - 0x00 locality select
  - 0x04 access
  - 0x08 interrupt enable
  - 0x14 interrupt capability
  - 0x18 to 0x1B status
  - 0x24 data FIFO
  - 0x30 interface capability
  - 0x38 device address
  - 0x40 checksum enable
  - 0x44 checksum value
  - 0x48 device/vendor id
  - 0x4C revision

  An index outside this map, or 0x38, is NAKed. Every later written byte of that transfer is also NAKed, and no back-end access results.
- R2: The buffer holds the index and up to four data bytes. A fifth data byte for a buffered register is NAKed and discarded.
- R3: Buffered data is assembled little-endian, with the first data byte in bits 7:0 and missing bytes zero. Stop issues one 4-byte back-end write, and only when at least one data byte was received. A stop with no data writes nothing.
- R4: After index 0x24, each data byte causes an immediate 1-byte back-end write at the FIFO address and is always ACKed. Stop adds no further write.
- R5: A write to index 0x00 stores its first data byte as the locality only if that byte is 0 to 4. Any other value leaves the locality unchanged. Reading index 0x00 returns the locality.
- R6: A write to index 0x40 keeps only bit 0 as the checksum enable, and reading index 0x40 returns it.
- R7: A status write at index 0x18+k with k>0 is a 1-byte write to back-end address 0x018+k. Its data is ANDed with 0x0F0040EC shifted right by 8k. With k=0 it is a 4-byte write masked by 0x0F0040EC.
- R8: Interrupt-enable write data is ANDed with 0x80000007 before it is forwarded.
- R9: The back-end address is the register's bus offset plus the locality shifted left by 12. The bus offsets are:
  - access 0x000
  - interrupt enable 0x008
  - status 0x018
  - FIFO 0x024
  - interface capability 0x014
  - device/vendor id 0xF00
  - revision 0xF04
- R10: The first read request after an index byte fetches the value once. The locality, checksum enable, the constant 0x80000007 (interrupt capability) and `csum_in` are served locally with no back-end access. Other registers use one 4-byte back-end read. Bytes come back lowest first, and read requests after the fourth byte return 0x00.
- R11: A status read uses back-end address 0x018 plus locality. The value is ANDed with 0x03FFFFFF and shifted right by 8k for index 0x18+k.
- R12: Reads of index 0x24 are never cached. Every read request issues a fresh 1-byte back-end read and returns its bits 7:0.
- R13: `evt_ready` stays low while an offered event's back-end request is not ready. `rsp_valid` pulses exactly one cycle after each accepted event.
- R14: Reset clears the locality and the checksum enable to 0 and leaves `rsp_valid` and `be_req_valid` low with `evt_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | PHY event offered |
| evt_ready | output | 1 | Event accepted this cycle when high with evt_valid |
| evt_kind | input | 3 | Event kind code (R1) |
| evt_wdata | input | 8 | Written byte for kind 2 |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_nak | output | 1 | 1 = NAK for the accepted event |
| rsp_rdata | output | 8 | Byte returned for a read request |
| be_req_valid | output | 1 | Back-end access request |
| be_req_ready | input | 1 | Back end completes the access this cycle |
| be_we | output | 1 | 1 = write, 0 = read |
| be_addr | output | ADDR_W | Back-end byte address including locality |
| be_wdata | output | 32 | Back-end write data |
| be_size | output | 3 | Access size in bytes, 1 or 4 |
| be_rdata | input | 32 | Back-end read data, valid with the handshake |
| csum_in | input | 32 | Checksum value returned for index 0x44 |

## Verification
A stale or wrong locality shows up in the top address bits of the very next back-end access, and again in the locality read-back. A miscounted write buffer shows up as an ACK/NAK flip on the fifth data byte, one cycle after that byte is accepted. It also shows as a misplaced byte in the write issued at stop. A bad read-cache pointer or a missed refetch shows up in the byte order on `rsp_rdata`, or in the number of back-end reads seen during a read transfer.

// File: rtl/i2c_tpm_bridge_pkg.sv
package i2c_tpm_bridge_pkg;
  localparam int BUS_BYTES = 4;
  localparam int BUS_W     = 8 * BUS_BYTES;
  localparam int CNT_W     = $clog2(BUS_BYTES + 2);
  localparam int PTR_W     = $clog2(BUS_BYTES + 1);

  typedef enum logic [2:0] {
    EV_START_WR = 3'd0,
    EV_START_RD = 3'd1,
    EV_WR_BYTE  = 3'd2,
    EV_RD_REQ   = 3'd3,
    EV_STOP     = 3'd4
  } evt_e;

  typedef enum logic [3:0] {
    RK_NONE, RK_LOC, RK_ACCESS, RK_INTEN, RK_INTCAP, RK_STS, RK_FIFO,
    RK_INTF, RK_DEVADR, RK_CSEN, RK_CSGET, RK_DID, RK_RID
  } reg_e;

  typedef enum logic [1:0] {OP_IDLE, OP_SEND, OP_RECV} op_e;

  localparam logic [7:0] IX_LOC    = 8'h00;
  localparam logic [7:0] IX_ACCESS = 8'h04;
  localparam logic [7:0] IX_INTEN  = 8'h08;
  localparam logic [7:0] IX_INTCAP = 8'h14;
  localparam logic [7:0] IX_STS    = 8'h18;
  localparam logic [7:0] IX_FIFO   = 8'h24;
  localparam logic [7:0] IX_INTF   = 8'h30;
  localparam logic [7:0] IX_DEVADR = 8'h38;
  localparam logic [7:0] IX_CSEN   = 8'h40;
  localparam logic [7:0] IX_CSGET  = 8'h44;
  localparam logic [7:0] IX_DID    = 8'h48;
  localparam logic [7:0] IX_RID    = 8'h4C;

  localparam logic [BUS_W-1:0] INT_EN_MASK = 32'h8000_0007;
  localparam logic [BUS_W-1:0] STS_WR_MASK = 32'h0F00_40EC;
  localparam logic [BUS_W-1:0] STS_RD_MASK = 32'h03FF_FFFF;
endpackage

// File: rtl/bridge_regmap.sv
module bridge_regmap
  import i2c_tpm_bridge_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [7:0]        idx,
  output reg_e              kind,
  output logic [ADDR_W-1:0] tis_off,
  output logic [1:0]        sts_off
);
  always_comb begin
    kind    = RK_NONE;
    tis_off = '0;
    sts_off = 2'd0;
    if (idx[7:2] == IX_STS[7:2]) begin
      kind    = RK_STS;
      tis_off = ADDR_W'(12'h018);
      sts_off = idx[1:0];
    end else begin
      case (idx)
        IX_LOC:    kind = RK_LOC;
        IX_ACCESS: begin kind = RK_ACCESS; tis_off = ADDR_W'(12'h000); end
        IX_INTEN:  begin kind = RK_INTEN;  tis_off = ADDR_W'(12'h008); end
        IX_INTCAP: kind = RK_INTCAP;
        IX_FIFO:   begin kind = RK_FIFO;   tis_off = ADDR_W'(12'h024); end
        IX_INTF:   begin kind = RK_INTF;   tis_off = ADDR_W'(12'h014); end
        IX_DEVADR: kind = RK_DEVADR;
        IX_CSEN:   kind = RK_CSEN;
        IX_CSGET:  kind = RK_CSGET;
        IX_DID:    begin kind = RK_DID;    tis_off = ADDR_W'(12'hF00); end
        IX_RID:    begin kind = RK_RID;    tis_off = ADDR_W'(12'hF04); end
        default:   kind = RK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/bridge_wfmt.sv
module bridge_wfmt
  import i2c_tpm_bridge_pkg::*;
(
  input  reg_e             kind,
  input  logic [1:0]       sts_off,
  input  logic [BUS_W-1:0] raw,
  output logic [BUS_W-1:0] data,
  output logic [2:0]       size
);
  always_comb begin
    data = raw;
    size = 3'd4;
    case (kind)
      RK_INTEN: data = raw & INT_EN_MASK;
      RK_STS: begin
        data = raw & (STS_WR_MASK >> {sts_off, 3'b000});
        if (sts_off != 2'd0) size = 3'd1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bridge_rfmt.sv
module bridge_rfmt
  import i2c_tpm_bridge_pkg::*;
#(
  parameter int LOC_W = 3
) (
  input  reg_e             kind,
  input  logic [1:0]       sts_off,
  input  logic [LOC_W-1:0] loc,
  input  logic             csen,
  input  logic [BUS_W-1:0] csum,
  input  logic [BUS_W-1:0] be_val,
  output logic [BUS_W-1:0] value,
  output logic             local_src
);
  always_comb begin
    local_src = 1'b1;
    value     = '0;
    case (kind)
      RK_LOC:    value = BUS_W'(loc);
      RK_CSEN:   value = BUS_W'(csen);
      RK_INTCAP: value = INT_EN_MASK;
      RK_CSGET:  value = csum;
      RK_STS: begin
        local_src = 1'b0;
        value = (be_val & STS_RD_MASK) >> {sts_off, 3'b000};
      end
      RK_FIFO: begin
        local_src = 1'b0;
        value = BUS_W'(be_val[7:0]);
      end
      default: begin
        local_src = 1'b0;
        value = be_val;
      end
    endcase
  end
endmodule

// File: rtl/i2c_tpm_bridge.sv
module i2c_tpm_bridge
  import i2c_tpm_bridge_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LOC_SHIFT = 12,
  parameter int NUM_LOC   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [2:0]        evt_kind,
  input  logic [7:0]        evt_wdata,
  output logic              rsp_valid,
  output logic              rsp_nak,
  output logic [7:0]        rsp_rdata,
  output logic              be_req_valid,
  input  logic              be_req_ready,
  output logic              be_we,
  output logic [ADDR_W-1:0] be_addr,
  output logic [BUS_W-1:0]  be_wdata,
  output logic [2:0]        be_size,
  input  logic [BUS_W-1:0]  be_rdata,
  input  logic [BUS_W-1:0]  csum_in
);
  localparam int LOC_W = $clog2(NUM_LOC);

  op_e              op_q;
  logic [7:0]       idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dead_q;
  logic [BUS_W-1:0] wb_q;
  logic [BUS_W-1:0] rc_q;
  logic [PTR_W-1:0] ptr_q;
  logic [LOC_W-1:0] loc_q;
  logic             csen_q;

  // index decode: the index byte itself while it is being written, else the held one
  logic       has_idx;
  logic [7:0] dec_idx;
  reg_e       kind;
  logic [ADDR_W-1:0] tis_off;
  logic [1:0] sts_off;

  assign has_idx = (cnt_q != '0);
  assign dec_idx = (evt_kind == EV_WR_BYTE && !has_idx) ? evt_wdata : idx_q;

  bridge_regmap #(.ADDR_W(ADDR_W)) u_map (
    .idx(dec_idx), .kind(kind), .tis_off(tis_off), .sts_off(sts_off)
  );

  logic [BUS_W-1:0] wr_data;
  logic [2:0]       wr_size;
  bridge_wfmt u_wfmt (
    .kind(kind), .sts_off(sts_off), .raw(wb_q), .data(wr_data), .size(wr_size)
  );

  logic [BUS_W-1:0] rd_value;
  logic             rd_local;
  bridge_rfmt #(.LOC_W(LOC_W)) u_rfmt (
    .kind(kind), .sts_off(sts_off), .loc(loc_q), .csen(csen_q), .csum(csum_in),
    .be_val(be_rdata), .value(rd_value), .local_src(rd_local)
  );

  // back-end demand of the offered event
  logic fwd_kind, fifo_wr, stop_wr, rd_fetch, rd_fifo, need_be, accept;
  assign fwd_kind = kind inside {RK_ACCESS, RK_INTEN, RK_STS, RK_INTF, RK_DID, RK_RID};
  assign fifo_wr  = (evt_kind == EV_WR_BYTE) && has_idx && !dead_q && (kind == RK_FIFO);
  assign stop_wr  = (evt_kind == EV_STOP) && (op_q == OP_SEND) &&
                    (cnt_q > CNT_W'(1)) && fwd_kind;
  assign rd_fetch = (evt_kind == EV_RD_REQ) && (op_q == OP_SEND) &&
                    (cnt_q == CNT_W'(1)) && !rd_local;
  assign rd_fifo  = (evt_kind == EV_RD_REQ) && (op_q == OP_RECV) && has_idx &&
                    (kind == RK_FIFO);
  assign need_be  = fifo_wr | stop_wr | rd_fetch | rd_fifo;

  assign be_req_valid = evt_valid && need_be;
  assign evt_ready    = !need_be || be_req_ready;
  assign accept       = evt_valid && evt_ready;
  assign be_we        = fifo_wr | stop_wr;
  assign be_wdata     = fifo_wr ? BUS_W'(evt_wdata) : wr_data;
  assign be_addr      = tis_off
                      + ((stop_wr && kind == RK_STS) ? ADDR_W'(sts_off) : '0)
                      + (ADDR_W'(loc_q) << LOC_SHIFT);

  always_comb begin
    if (stop_wr)                                       be_size = wr_size;
    else if (fifo_wr || rd_fifo || kind == RK_FIFO)    be_size = 3'd1;
    else                                               be_size = 3'd4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_IDLE;
      idx_q     <= '0;
      cnt_q     <= '0;
      dead_q    <= 1'b0;
      wb_q      <= '0;
      rc_q      <= '0;
      ptr_q     <= '0;
      loc_q     <= '0;
      csen_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_nak   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_nak   <= 1'b0;
        rsp_rdata <= '0;
        case (evt_kind)
          EV_START_WR: begin
            op_q <= OP_IDLE; idx_q <= '0; cnt_q <= '0; dead_q <= 1'b0;
            wb_q <= '0; rc_q <= '0; ptr_q <= '0;
          end
          EV_WR_BYTE: begin
            if (dead_q) begin
              rsp_nak <= 1'b1;
            end else if (!has_idx) begin
              if (kind == RK_NONE || kind == RK_DEVADR) begin
                rsp_nak <= 1'b1;
                dead_q  <= 1'b1;
              end else begin
                idx_q <= evt_wdata;
                cnt_q <= CNT_W'(1);
                op_q  <= OP_SEND;
              end
            end else if (kind == RK_FIFO) begin
              op_q <= OP_SEND;
            end else if (cnt_q >= CNT_W'(BUS_BYTES + 1)) begin
              rsp_nak <= 1'b1;
            end else begin
              for (int b = 0; b < BUS_BYTES; b++)
                if (cnt_q == CNT_W'(b + 1)) wb_q[b*8 +: 8] <= evt_wdata;
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          EV_RD_REQ: begin
            if (op_q == OP_RECV) begin
              if (rd_fifo) begin
                rsp_rdata <= be_rdata[7:0];
              end else if (ptr_q < PTR_W'(BUS_BYTES)) begin
                rsp_rdata <= rc_q[{ptr_q[1:0], 3'b000} +: 8];
                ptr_q     <= ptr_q + PTR_W'(1);
              end
            end else if (op_q == OP_SEND && cnt_q == CNT_W'(1)) begin
              rc_q      <= rd_value;
              rsp_rdata <= rd_value[7:0];
              ptr_q     <= PTR_W'(1);
              op_q      <= OP_RECV;
            end else begin
              op_q  <= OP_RECV;
              ptr_q <= PTR_W'(BUS_BYTES);
            end
          end
          EV_STOP: begin
            if (op_q == OP_SEND && cnt_q > CNT_W'(1)) begin
              if (kind == RK_LOC && wb_q[7:0] < 8'(NUM_LOC)) loc_q <= wb_q[LOC_W-1:0];
              if (kind == RK_CSEN) csen_q <= wb_q[0];
            end
            op_q <= OP_IDLE; idx_q <= '0; cnt_q <= '0; dead_q <= 1'b0;
            wb_q <= '0; rc_q <= '0; ptr_q <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bridge_chk.sv
module bridge_chk
  import i2c_tpm_bridge_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LOC_SHIFT = 12,
  parameter int NUM_LOC   = 5,
  localparam int LOC_W    = $clog2(NUM_LOC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic              rsp_valid,
  input logic              be_req_valid,
  input logic              be_req_ready,
  input logic [ADDR_W-1:0] be_addr,
  input logic [2:0]        be_size,
  input logic [CNT_W-1:0]  cnt,
  input logic [LOC_W-1:0]  loc
);
  assert_be_needs_event_R13: assert property (@(posedge clk) disable iff (!rst_n)
    be_req_valid |-> evt_valid);
  assert_stall_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req_valid && !be_req_ready) |-> !evt_ready);
  assert_rsp_after_accept_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(evt_valid && evt_ready));
  assert_size_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    be_req_valid |-> (be_size == 3'd1 || be_size == 3'd4));
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(BUS_BYTES + 1));
  assert_locality_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loc < LOC_W'(NUM_LOC));
  assert_addr_locality_R9: assert property (@(posedge clk) disable iff (!rst_n)
    be_req_valid |-> (be_addr[ADDR_W-1:LOC_SHIFT] == (ADDR_W-LOC_SHIFT)'(loc)));
endmodule

bind i2c_tpm_bridge bridge_chk #(.ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT), .NUM_LOC(NUM_LOC)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
  .rsp_valid(rsp_valid), .be_req_valid(be_req_valid), .be_req_ready(be_req_ready),
  .be_addr(be_addr), .be_size(be_size), .cnt(cnt_q), .loc(loc_q)
);

// File: tb/sim_i2c_tpm_bridge.sv
`timescale 1ns/1ps
module sim_i2c_tpm_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 1'b0, evt_ready;
  logic [2:0] evt_kind = 3'd0;
  logic [7:0] evt_wdata = 8'd0;
  logic rsp_valid, rsp_nak;
  logic [7:0] rsp_rdata;
  logic be_req_valid, be_req_ready, be_we;
  logic [15:0] be_addr;
  logic [31:0] be_wdata, be_rdata;
  logic [2:0] be_size;
  localparam logic [31:0] CSUM = 32'hC0DE_1234;

  always #4 clk = ~clk;

  i2c_tpm_bridge u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_kind(evt_kind), .evt_wdata(evt_wdata), .rsp_valid(rsp_valid),
    .rsp_nak(rsp_nak), .rsp_rdata(rsp_rdata), .be_req_valid(be_req_valid),
    .be_req_ready(be_req_ready), .be_we(be_we), .be_addr(be_addr),
    .be_wdata(be_wdata), .be_size(be_size), .be_rdata(be_rdata), .csum_in(CSUM)
  );

  function automatic logic [31:0] mdl(input logic [15:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction
  assign be_rdata = mdl(be_addr);

  // back-end model: optional two-cycle stall per request, access capture
  logic stall_en = 1'b0;
  int stall_cnt = 0;
  assign be_req_ready = !stall_en || (stall_cnt >= 2);
  int wr_n = 0, rd_n = 0;
  logic [15:0] w_addr, r_addr;
  logic [31:0] w_data;
  logic [2:0]  w_size, r_size;
  always @(posedge clk) begin
    if (!be_req_valid) stall_cnt <= 0;
    else if (!be_req_ready) stall_cnt <= stall_cnt + 1;
    if (be_req_valid && be_req_ready) begin
      if (be_we) begin
        wr_n <= wr_n + 1; w_addr <= be_addr; w_data <= be_wdata; w_size <= be_size;
      end else begin
        rd_n <= rd_n + 1; r_addr <= be_addr; r_size <= be_size;
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;
  logic r_vld, r_nak;
  logic [7:0] r_dat;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ev(input logic [2:0] k, input logic [7:0] b);
    @(negedge clk);
    evt_valid = 1'b1; evt_kind = k; evt_wdata = b;
    while (!evt_ready) @(negedge clk);
    @(negedge clk);
    evt_valid = 1'b0;
    r_vld = rsp_valid; r_nak = rsp_nak; r_dat = rsp_rdata;
  endtask

  task automatic wr_txn(input logic [7:0] idx, input int n, input logic [31:0] d);
    ev(3'd0, 8'h00);
    ev(3'd2, idx);
    for (int i = 0; i < n; i++) ev(3'd2, d[i*8 +: 8]);
    ev(3'd4, 8'h00);
  endtask

  task automatic rd_open(input logic [7:0] idx);
    ev(3'd0, 8'h00);
    ev(3'd2, idx);
    ev(3'd1, 8'h00);
  endtask

  typedef struct packed {
    logic [7:0]  idx;
    logic [2:0]  n;
    logic [31:0] data;
    logic        we;
    logic [15:0] addr;
    logic [31:0] edata;
    logic [2:0]  size;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{8'h04, 3'd1, 32'h0000_0002, 1'b1, 16'h0000, 32'h0000_0002, 3'd4},
    '{8'h08, 3'd4, 32'hFFFF_FFFF, 1'b1, 16'h0008, 32'h8000_0007, 3'd4},
    '{8'h18, 3'd4, 32'hFFFF_FFFF, 1'b1, 16'h0018, 32'h0F00_40EC, 3'd4},
    '{8'h1B, 3'd1, 32'h0000_00FF, 1'b1, 16'h001B, 32'h0000_000F, 3'd1},
    '{8'h19, 3'd1, 32'h0000_00FF, 1'b1, 16'h0019, 32'h0000_0040, 3'd1},
    '{8'h4C, 3'd2, 32'h0000_1234, 1'b1, 16'h0F04, 32'h0000_1234, 3'd4},
    '{8'h04, 3'd0, 32'h0000_0000, 1'b0, 16'h0000, 32'h0000_0000, 3'd4}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int w0, r0;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R14 reset state
    chk("R14 rsp_valid", 32'(rsp_valid), 0);
    chk("R14 be_req_valid", 32'(be_req_valid), 0);
    chk("R14 evt_ready", 32'(evt_ready), 1);
    rst_n = 1'b1;
    rd_open(8'h00); ev(3'd3, 8'h00);
    chk("R14 locality after reset", 32'(r_dat), 0);
    chk("R13 rsp pulse", 32'(r_vld), 1);
    @(negedge clk);
    chk("R13 rsp single cycle", 32'(rsp_valid), 0);
    ev(3'd4, 8'h00);

    // vector table: buffered writes (R3, R7, R8, R9)
    foreach (VEC[i]) begin
      w0 = wr_n;
      wr_txn(VEC[i].idx, int'(VEC[i].n), VEC[i].data);
      chk($sformatf("R3 write count vec%0d", i), 32'(wr_n - w0), 32'(VEC[i].we));
      if (VEC[i].we) begin
        chk($sformatf("R9 addr vec%0d", i), 32'(w_addr), 32'(VEC[i].addr));
        chk($sformatf("R7/R8 data vec%0d", i), w_data, VEC[i].edata);
        chk($sformatf("R7 size vec%0d", i), 32'(w_size), 32'(VEC[i].size));
      end
    end

    // R1 unknown index and device-address index
    w0 = wr_n; r0 = rd_n;
    ev(3'd0, 8'h00); ev(3'd2, 8'h10);
    chk("R1 unknown index NAK", 32'(r_nak), 1);
    ev(3'd2, 8'h55);
    chk("R1 later byte NAK", 32'(r_nak), 1);
    ev(3'd4, 8'h00);
    ev(3'd0, 8'h00); ev(3'd2, 8'h38);
    chk("R1 device address NAK", 32'(r_nak), 1);
    ev(3'd4, 8'h00);
    chk("R1 no back-end access", 32'(wr_n - w0 + rd_n - r0), 0);

    // R2 buffer limit
    ev(3'd0, 8'h00); ev(3'd2, 8'h04);
    ev(3'd2, 8'h11); ev(3'd2, 8'h22); ev(3'd2, 8'h33); ev(3'd2, 8'h44);
    chk("R2 fourth data byte ACK", 32'(r_nak), 0);
    ev(3'd2, 8'h55);
    chk("R2 fifth data byte NAK", 32'(r_nak), 1);
    ev(3'd4, 8'h00);
    chk("R2 committed data", w_data, 32'h4433_2211);

    // R4 FIFO pass-through with a stalling back end
    stall_en = 1'b1;
    ev(3'd0, 8'h00); ev(3'd2, 8'h24);
    w0 = wr_n;
    ev(3'd2, 8'hAA);
    chk("R4 immediate write", 32'(wr_n - w0), 1);
    chk("R4 fifo addr", 32'(w_addr), 32'h0024);
    chk("R4 fifo data", w_data, 32'h0000_00AA);
    chk("R4 fifo size", 32'(w_size), 1);
    for (int i = 0; i < 6; i++) ev(3'd2, 8'(i));
    chk("R4 long fifo burst ACK", 32'(r_nak), 0);
    ev(3'd4, 8'h00);
    chk("R4 no write at stop", 32'(wr_n - w0), 7);
    stall_en = 1'b0;

    // R5 locality, R9 address injection
    wr_txn(8'h00, 1, 32'h3);
    wr_txn(8'h04, 1, 32'h1);
    chk("R9 locality in address", 32'(w_addr), 32'h3000);
    wr_txn(8'h00, 1, 32'h7);
    rd_open(8'h00); ev(3'd3, 8'h00);
    chk("R5 invalid locality ignored", 32'(r_dat), 3);
    ev(3'd3, 8'h00); ev(3'd3, 8'h00); ev(3'd3, 8'h00); ev(3'd3, 8'h00);
    chk("R10 read past four bytes", 32'(r_dat), 0);
    ev(3'd4, 8'h00);

    // R6 checksum enable
    wr_txn(8'h40, 1, 32'hFF);
    rd_open(8'h40); ev(3'd3, 8'h00);
    chk("R6 enable bit only", 32'(r_dat), 1);
    ev(3'd4, 8'h00);

    // R10 local sources
    r0 = rd_n;
    rd_open(8'h14); ev(3'd3, 8'h00);
    chk("R10 int cap byte0", 32'(r_dat), 32'h07);
    ev(3'd3, 8'h00); ev(3'd3, 8'h00); ev(3'd3, 8'h00);
    chk("R10 int cap byte3", 32'(r_dat), 32'h80);
    ev(3'd4, 8'h00);
    rd_open(8'h44); ev(3'd3, 8'h00);
    chk("R10 checksum byte0", 32'(r_dat), 32'h34);
    ev(3'd4, 8'h00);
    chk("R10 local reads use no back end", 32'(rd_n - r0), 0);

    // R11 status read at locality 3, cached (R10)
    v = mdl(16'h3018) & 32'h03FF_FFFF;
    r0 = rd_n;
    rd_open(8'h18);
    for (int i = 0; i < 4; i++) begin
      ev(3'd3, 8'h00);
      chk($sformatf("R11 status byte%0d", i), 32'(r_dat), 32'(v[i*8 +: 8]));
    end
    ev(3'd4, 8'h00);
    chk("R10 single fetch", 32'(rd_n - r0), 1);
    rd_open(8'h1A); ev(3'd3, 8'h00);
    chk("R11 offset addr", 32'(r_addr), 32'h3018);
    chk("R11 offset byte0", 32'(r_dat), 32'(v[23:16]));
    ev(3'd3, 8'h00); ev(3'd3, 8'h00);
    chk("R11 offset byte2 zero", 32'(r_dat), 0);
    ev(3'd4, 8'h00);

    // R12 FIFO reads uncached
    r0 = rd_n;
    rd_open(8'h24);
    for (int i = 0; i < 3; i++) begin
      ev(3'd3, 8'h00);
      chk("R12 fifo byte", 32'(r_dat), 32'(mdl(16'h3024) & 32'hFF));
    end
    ev(3'd4, 8'h00);
    chk("R12 read per byte", 32'(rd_n - r0), 3);
    chk("R12 read size", 32'(r_size), 1);

    // R9/R10 id read
    rd_open(8'h48); ev(3'd3, 8'h00); ev(3'd3, 8'h00);
    chk("R10 id byte1", 32'(r_dat), 32'(mdl(16'h3F00) >> 8) & 32'hFF);
    ev(3'd4, 8'h00);

    // R14 reset clears locality and checksum enable
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_open(8'h00); ev(3'd3, 8'h00);
    chk("R14 locality cleared", 32'(r_dat), 0);
    ev(3'd4, 8'h00);
    rd_open(8'h40); ev(3'd3, 8'h00);
    chk("R14 checksum enable cleared", 32'(r_dat), 0);
    ev(3'd4, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule